// File: doc/BRIEF.md
# Spike Event Packet Encoder

This block sits at a leaf node of a hierarchical interconnect for spiking neural hardware. Every clock cycle it samples the spike lines of a small group of neurons. Whenever at least one neuron fires, it produces one fixed-size 48-bit packet for the local router. Neurons that fire together do not produce one packet each. They share a single packet whose source field holds a bitmask of every neuron that fired.

The packet is offered on a valid/ready handshake. The router may stall the packet for any number of cycles. During a stall the packet on the outputs does not change. Spikes that arrive during the stall are collected into a pending mask. At the handshake, the pending mask is merged with any spikes of that same cycle into the next packet, so no spike is dropped.

The header carries a fixed type code chosen by a parameter. The target field comes from a per-node configuration register that software loads through a simple write strobe.

Top module: `spike_pkt_enc`

## Requirements
- R1: Packet layout: bits 47:44 hold the header code `HDR_CODE` (default 4'hF), bits 43:14 hold the 30-bit target address, and bits 13:0 hold the source field.
- R2: In the source field, bit i is 1 exactly when neuron i is reported in that packet. Bits 13 down to `N_NEURON` (default 10) are always 0.
- R3: Any number of neurons firing in the same cycle produce exactly one packet that marks all of them.
- R4: No packet is offered (valid stays low) while no neuron has fired since the last packet was taken. An offered packet never has an empty source field.
- R5: When the encoder is idle, a spike sampled at a rising edge makes valid high right after that edge, so the packet appears one cycle later.
- R6: While valid is high and ready is low, valid stays high and all 48 packet bits stay unchanged.
- R7: Spikes sampled while a packet is stalled are collected. The packet issued right after the handshake reports the union of those spikes and the spikes sampled in the handshake cycle.
- R8: A handshake in a cycle with nothing pending and no new spike lowers valid after that edge.
- R9: A write on the configuration strobe replaces the target address for packets formed at later edges. It does not change a packet already being offered.
- R10: A synchronous reset lowers valid, clears the pending mask and restores the target register to `TGT_RST` (default 30'h202).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| spike_i | input | N_NEURON | Spike line per neuron, sampled each cycle |
| cfg_tgt_we | input | 1 | Write strobe for the target register |
| cfg_tgt_data | input | 30 | New target address value |
| pkt_ready_i | input | 1 | Router accepts the packet |
| pkt_valid_o | output | 1 | Packet offered |
| pkt_data_o | output | 48 | Packet: header, target, source |

## Verification
The hardest situation to reach from the ports is a handshake that happens in the same cycle as fresh spikes while earlier spikes are still pending. Getting it wrong either drops the spikes or splits them into extra packets. The stimulus first holds ready low over several spike cycles to fill the pending mask. It then raises ready in the same cycle as a new spike and checks that the very next packet is their union. A second sequence repeats a single neuron in consecutive accepted cycles to check back-to-back packets. A target write during a stall and a reset during a stall with spikes pending cover the configuration and reset corners.

// File: rtl/spk_pkg.sv
package spk_pkg;
  localparam int HDR_W = 4;
  localparam int TGT_W = 30;
  localparam int SRC_W = 14;
  localparam int PKT_W = HDR_W + TGT_W + SRC_W;
  localparam int SRC_LSB = 0;
  localparam int TGT_LSB = SRC_LSB + SRC_W;
  localparam int HDR_LSB = TGT_LSB + TGT_W;

  typedef logic [HDR_W-1:0] hdr_t;
  typedef logic [TGT_W-1:0] tgt_t;
  typedef logic [SRC_W-1:0] src_t;
  typedef logic [PKT_W-1:0] pkt_t;

  // Assemble a packet from its three fields.
  function automatic pkt_t pack_pkt(hdr_t hdr, tgt_t tgt, src_t src);
    pkt_t p;
    p = '0;
    p[HDR_LSB +: HDR_W] = hdr;
    p[TGT_LSB +: TGT_W] = tgt;
    p[SRC_LSB +: SRC_W] = src;
    return p;
  endfunction

  function automatic hdr_t pkt_hdr(pkt_t p);
    return p[HDR_LSB +: HDR_W];
  endfunction

  function automatic src_t pkt_src(pkt_t p);
    return p[SRC_LSB +: SRC_W];
  endfunction
endpackage

// File: rtl/spk_tgt_reg.sv
module spk_tgt_reg
  import spk_pkg::*;
#(
  parameter tgt_t RST_VAL = tgt_t'(30'h202)
) (
  input  logic clk,
  input  logic rst,
  input  logic we,
  input  tgt_t wdata,
  output tgt_t tgt
);
  always_ff @(posedge clk) begin
    if (rst)     tgt <= RST_VAL;
    else if (we) tgt <= wdata;
  end
endmodule

// File: rtl/spk_mask_acc.sv
module spk_mask_acc #(
  parameter int N = 10
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] spike,
  input  logic         take,    // output slot free this cycle
  output logic [N-1:0] merged,  // pending OR current spikes
  output logic [N-1:0] pend
);
  assign merged = pend | spike;

  always_ff @(posedge clk) begin
    if (rst)       pend <= '0;
    else if (take) pend <= '0;
    else           pend <= merged;
  end
endmodule

// File: rtl/spk_pkt_out.sv
module spk_pkt_out
  import spk_pkg::*;
#(
  parameter hdr_t HDR = hdr_t'(4'hF)
) (
  input  logic clk,
  input  logic rst,
  input  logic take,
  input  src_t src,
  input  tgt_t tgt,
  output logic valid,
  output pkt_t data
);
  logic any_w;
  assign any_w = |src;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= 1'b0;
      data  <= '0;
    end else if (take) begin
      valid <= any_w;
      if (any_w) data <= pack_pkt(HDR, tgt, src);
    end
  end
endmodule

// File: rtl/spike_pkt_enc.sv
module spike_pkt_enc
  import spk_pkg::*;
#(
  parameter int   N_NEURON = 10,
  parameter hdr_t HDR_CODE = hdr_t'(4'hF),
  parameter tgt_t TGT_RST  = tgt_t'(30'h202)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [N_NEURON-1:0] spike_i,
  input  logic                cfg_tgt_we,
  input  logic [TGT_W-1:0]    cfg_tgt_data,
  input  logic                pkt_ready_i,
  output logic                pkt_valid_o,
  output logic [PKT_W-1:0]    pkt_data_o
);
  // Named internal events, observed by the bound checker.
  logic                free_w;
  logic [N_NEURON-1:0] merged_w;
  logic [N_NEURON-1:0] pend_w;
  src_t                src_w;
  tgt_t                tgt_w;

  assign free_w = !pkt_valid_o || pkt_ready_i;

  generate
    for (genvar i = 0; i < SRC_W; i++) begin : g_src
      if (i < N_NEURON) begin : g_used
        assign src_w[i] = merged_w[i];
      end else begin : g_pad
        assign src_w[i] = 1'b0;
      end
    end
  endgenerate

  spk_tgt_reg #(.RST_VAL(TGT_RST)) u_tgt (
    .clk(clk), .rst(rst), .we(cfg_tgt_we), .wdata(cfg_tgt_data), .tgt(tgt_w)
  );

  spk_mask_acc #(.N(N_NEURON)) u_acc (
    .clk(clk), .rst(rst), .spike(spike_i), .take(free_w),
    .merged(merged_w), .pend(pend_w)
  );

  spk_pkt_out #(.HDR(HDR_CODE)) u_out (
    .clk(clk), .rst(rst), .take(free_w), .src(src_w), .tgt(tgt_w),
    .valid(pkt_valid_o), .data(pkt_data_o)
  );
endmodule

// File: rtl/spike_pkt_enc_chk.sv
module spike_pkt_enc_chk
  import spk_pkg::*;
#(
  parameter int   N   = 10,
  parameter hdr_t HDR = hdr_t'(4'hF)
) (
  input logic         clk,
  input logic         rst,
  input logic [N-1:0] spike,
  input logic         ready,
  input logic         valid,
  input pkt_t         data,
  input logic [N-1:0] merged,
  input logic [N-1:0] pend
);
  a_r1_header: assert property (@(posedge clk) disable iff (rst)
    valid |-> pkt_hdr(data) == HDR);

  a_r2_upper_zero: assert property (@(posedge clk) disable iff (rst)
    valid |-> (pkt_src(data) >> N) == '0);

  a_r4_nonempty: assert property (@(posedge clk) disable iff (rst)
    valid |-> pkt_src(data) != '0);

  a_r5_launch: assert property (@(posedge clk) disable iff (rst)
    (!valid && (|spike)) |=> valid);

  a_r6_hold: assert property (@(posedge clk) disable iff (rst)
    (valid && !ready) |=> (valid && $stable(data)));

  a_r7_collect: assert property (@(posedge clk) disable iff (rst)
    (valid && !ready) |=> ((pend & $past(spike)) == $past(spike)));

  a_r8_drop: assert property (@(posedge clk) disable iff (rst)
    (valid && ready && merged == '0) |=> !valid);

  a_r10_reset: assert property (@(posedge clk)
    rst |=> (!valid && pend == '0));
endmodule

bind spike_pkt_enc spike_pkt_enc_chk #(.N(N_NEURON), .HDR(HDR_CODE)) u_chk (
  .clk(clk), .rst(rst), .spike(spike_i), .ready(pkt_ready_i),
  .valid(pkt_valid_o), .data(pkt_data_o), .merged(merged_w), .pend(pend_w)
);

// File: tb/spike_pkt_enc_tb.sv
module spike_pkt_enc_tb;
  localparam int N = 10;
  localparam logic [29:0] TGT0 = 30'h202;
  localparam logic [29:0] TGT1 = 30'h1ABC_0120;

  logic          clk = 1'b0;
  logic          rst;
  logic [N-1:0]  spike;
  logic          cfg_we;
  logic [29:0]   cfg_data;
  logic          ready;
  logic          valid;
  logic [47:0]   data;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #2 clk = ~clk;

  spike_pkt_enc u_dut (
    .clk(clk), .rst(rst), .spike_i(spike), .cfg_tgt_we(cfg_we),
    .cfg_tgt_data(cfg_data), .pkt_ready_i(ready),
    .pkt_valid_o(valid), .pkt_data_o(data)
  );

  // Expected packet: header F in the top nibble, target next, mask at bit 0.
  function automatic logic [47:0] expect_pkt(logic [29:0] t, logic [N-1:0] m);
    logic [47:0] r;
    r = 48'hF << 44;
    r = r | (48'(t) << 14);
    r = r | 48'(m);
    return r;
  endfunction

  task automatic check(bit ok, string req, logic [47:0] act, logic [47:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(logic [N-1:0] s, logic r);
    @(negedge clk);
    spike = s;
    ready = r;
    @(posedge clk);
    #1;
  endtask

  // {spike, ready, expected valid, expected source mask}
  localparam int NV = 14;
  localparam logic [21:0] VEC [NV] = '{
    {10'h000, 1'b1, 1'b0, 10'h000},  // idle: no packet (R4)
    {10'h041, 1'b1, 1'b1, 10'h041},  // two neurons together, one packet (R3 R5)
    {10'h000, 1'b0, 1'b1, 10'h041},  // stall holds (R6)
    {10'h200, 1'b0, 1'b1, 10'h041},  // spike during stall collected (R7)
    {10'h002, 1'b1, 1'b1, 10'h202},  // handshake + same-cycle spike merged (R7)
    {10'h000, 1'b1, 1'b0, 10'h000},  // nothing pending: drop (R8)
    {10'h3FF, 1'b0, 1'b1, 10'h3FF},  // all neurons (R2 R3)
    {10'h001, 1'b0, 1'b1, 10'h3FF},  // stall, collect bit 0 (R6 R7)
    {10'h000, 1'b1, 1'b1, 10'h001},  // pending issued (R7)
    {10'h000, 1'b0, 1'b1, 10'h001},  // hold (R6)
    {10'h000, 1'b1, 1'b0, 10'h000},  // drop (R8)
    {10'h100, 1'b1, 1'b1, 10'h100},  // launch (R5)
    {10'h100, 1'b1, 1'b1, 10'h100},  // back-to-back same neuron (R7)
    {10'h000, 1'b1, 1'b0, 10'h000}   // drop (R8)
  };

  initial begin
    rst = 1'b1; spike = '0; ready = 1'b0; cfg_we = 1'b0; cfg_data = '0;
    repeat (3) @(posedge clk);
    #1;
    check(valid == 1'b0, "R10 reset valid", 48'(valid), 48'h0);
    @(negedge clk);
    rst = 1'b0;

    for (int k = 0; k < NV; k++) begin
      logic [N-1:0] vs, vm;
      logic vr, vv;
      {vs, vr, vv, vm} = VEC[k];
      step(vs, vr);
      check(valid == vv, "R3 R4 R5 R6 R7 R8 valid", 48'(valid), 48'(vv));
      if (vv)
        check(data == expect_pkt(TGT0, vm), "R1 R2 R3 R7 packet",
              data, expect_pkt(TGT0, vm));
    end

    // R9: target write during a stall leaves the offered packet alone
    step(10'h010, 1'b0);
    check(data == expect_pkt(TGT0, 10'h010), "R9 before write", data, expect_pkt(TGT0, 10'h010));
    @(negedge clk);
    spike = '0; cfg_we = 1'b1; cfg_data = TGT1;
    @(posedge clk); #1;
    check(valid && data == expect_pkt(TGT0, 10'h010), "R9 in-flight unchanged",
          data, expect_pkt(TGT0, 10'h010));
    @(negedge clk);
    cfg_we = 1'b0;
    step(10'h020, 1'b1);
    check(valid && data == expect_pkt(TGT1, 10'h020), "R9 new target",
          data, expect_pkt(TGT1, 10'h020));
    step(10'h000, 1'b1);
    check(valid == 1'b0, "R8 drop after R9", 48'(valid), 48'h0);

    // R10: reset while stalled with spikes pending
    step(10'h004, 1'b0);
    step(10'h008, 1'b0);
    @(negedge clk);
    rst = 1'b1; spike = '0;
    @(posedge clk); #1;
    check(valid == 1'b0, "R10 reset mid-stall", 48'(valid), 48'h0);
    @(negedge clk);
    rst = 1'b0;
    step(10'h000, 1'b1);
    check(valid == 1'b0, "R10 pending cleared", 48'(valid), 48'h0);
    step(10'h080, 1'b1);
    check(valid && data == expect_pkt(TGT0, 10'h080), "R10 target restored",
          data, expect_pkt(TGT0, 10'h080));
    step(10'h000, 1'b1);

    // R4: long idle stretch, no packets
    for (int k = 0; k < 6; k++) begin
      step(10'h000, 1'b1);
      check(valid == 1'b0, "R4 idle", 48'(valid), 48'h0);
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule